// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the MII management interface. Software programs a clock divider, a PHY and register address and, for writes, a 16-bit value. It then writes a command. The block derives the management clock from the system clock and shifts a complete management frame onto the serial data line. For reads it releases the line and collects the PHY's answer. A busy flag and a data-not-ready flag let software poll for completion. After polling, software reads the result and writes zero to the command register.

A scan command runs read frames back to back against the same register for as long as its command bit stays set. Each completed scan frame refreshes the receive data register. It also refreshes a link-fail flag, which takes the inverse of bit 2 of the returned word, so scan is normally aimed at the PHY status register (register 1). The preamble of 32 ones can be switched off for PHYs that accept frames without it.

Top module: `mdio_master`

## Requirements
- R1: After reset the mode, command, address, transmit, receive and status registers read 0, and `mdc`, `mdio_out` and `mdio_oe` are low.
- R2: The register window sits at index 0 = mode, 1 = command, 2 = address, 3 = transmit data, 4 = receive data, 5 = status. Mode bits 7:0 hold the divider and always read back with bit 0 cleared. The command register reads back the value last written to bits 2:0. The address register keeps the PHY address in bits 4:0 and the register address in bits 12:8, and every other bit reads 0.
- R3: The MDC period is the divider value in system clocks, with divider values below 2 treated as 2. MDC is high for the second half of each period, and a frame of N bits keeps busy high for exactly N periods.
- R4: A write frame (command bit 2 alone) puts these bits on `mdio_out`, most significant bit first, with `mdio_oe` high for every bit: 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register address, then 10, then the 16 transmit data bits.
- R5: A read frame drives the 32 ones, then 01, then opcode 10, then the PHY address and the register address. It then holds `mdio_oe` low for the 2 turnaround bits and the 16 data bits. The data bits are sampled from `mdio_in` on MDC rising edges, most significant bit first, into bits 15:0 of the receive data register.
- R6: With mode bit 8 set, the 32-bit preamble is left out and the frame starts directly with 01.
- R7: `mdio_out` and `mdio_oe` never change while MDC is high. They change on MDC falling edges, or while MDC is low when a frame is launched.
- R8: Status bit 1 (busy) is high from the clock edge that accepts a nonzero command write until the frame's last falling MDC edge. A command written while busy starts nothing.
- R9: Status bit 2 is set when a read or scan is accepted. It clears on the edge where the first received word is stored.
- R10: Command bit 0 (scan) repeats read frames while it stays set. Each completed scan frame updates the receive data register and sets status bit 0 (link fail) to the inverse of bit 2 of that word. Clearing bit 0 ends the scan after the current frame finishes.
- R11: When several command bits are written together, scan takes priority over read, and read takes priority over write.
- R12: While idle, `mdc` and `mdio_oe` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the serial data pad |
| mdio_in | input | 1 | Serial data from the PHY |

## Verification
On every cycle the assertions check four things. The data line and its enable hold still while MDC is high. The line is quiet and MDC is low whenever the block is idle. Busy rises only on the edge after a command write and falls only together with a falling MDC. The data-not-ready flag clears only on a completed frame. The exact bit order of write and read frames, the divider arithmetic, preamble suppression, command priority and the scan loop's data and link-fail updates can only be shown by the bench's scenarios. In those scenarios a PHY model captures the serial stream and returns chosen words.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the management master.
// Assumes a 3-bit register index; the field layout inside each register is set by the top.
package mdio_pkg;
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_SCAN  = 2'd2
    } mgmt_op_e;

    localparam logic [2:0] REG_MODE   = 3'd0;
    localparam logic [2:0] REG_CMD    = 3'd1;
    localparam logic [2:0] REG_ADDR   = 3'd2;
    localparam logic [2:0] REG_TXDATA = 3'd3;
    localparam logic [2:0] REG_RXDATA = 3'd4;
    localparam logic [2:0] REG_STATUS = 3'd5;
endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
// Management clock generator: while run is high, produces a clock whose period is
// div system clocks, low for the first half and high for the second.
// rise_tick/fall_tick mark the cycles whose edge raises/lowers mdc.
// Assumes div is even and at least 2; the counter restarts whenever run is low.
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;

    assign half      = div >> 1;
    assign rise_tick = run && (cnt == half - 1'b1);
    assign fall_tick = run && (cnt == div - 1'b1);

    // Phase counter: wraps at the end of each period, parked at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || fall_tick) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    // Clock output: set at mid-period, cleared at period end or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  mdc <= 1'b0;
        else if (rise_tick)  mdc <= 1'b1;
        else if (fall_tick)  mdc <= 1'b0;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
// Frame engine: walks a bit index through preamble and frame, drives the serial
// line from a latched frame word, releases it for read turnaround and data, and
// shifts in read data on rising-edge ticks. Restarts itself for scan while scan_hold.
// Assumes start is only asserted while idle and ticks come from mdio_clk_gen.
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PHY_W   = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mgmt_op_e          op_in,
    input  logic              nopre_in,
    input  logic [PHY_W-1:0]  phy_in,
    input  logic [PHY_W-1:0]  reg_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              scan_hold,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              busy,
    output mgmt_op_e          op_out,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              frame_done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int FRAME_W = 6 + 2 * PHY_W + DATA_W;
    localparam int TOTAL   = PRE_LEN + FRAME_W;
    localparam int IDX_W   = $clog2(TOTAL) + 1;
    localparam int FPOS_W  = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_LEN + 4 + 2 * PHY_W);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 6 + 2 * PHY_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   fpos;
    logic [FRAME_W-1:0] frame_q;
    logic               nopre_q;
    mgmt_op_e           op_q;
    logic [DATA_W-1:0]  rx_sh;

    assign fpos       = LAST_IDX - idx;
    assign op_out     = op_q;
    assign rx_word    = rx_sh;
    assign frame_done = busy && fall_tick && (idx == LAST_IDX);
    assign mdio_out   = busy && ((idx < PRE_IDX) || frame_q[fpos[FPOS_W-1:0]]);
    assign mdio_oe    = busy && ((op_q == OP_WRITE) || (idx < REL_IDX));

    // Frame sequencing: launch, advance on falling ticks, end or loop for scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            op_q    <= OP_WRITE;
            nopre_q <= 1'b0;
            frame_q <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            idx     <= nopre_in ? PRE_IDX : '0;
            op_q    <= op_in;
            nopre_q <= nopre_in;
            frame_q <= {2'b01, (op_in == OP_WRITE) ? 2'b01 : 2'b10,
                        phy_in, reg_in, 2'b10, wdata_in};
        end else if (frame_done) begin
            if (op_q == OP_SCAN && scan_hold) idx  <= nopre_q ? PRE_IDX : '0;
            else                               busy <= 1'b0;
        end else if (busy && fall_tick) begin
            idx <= idx + 1'b1;
        end
    end

    // Read capture: shift in one data bit per rising tick during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sh <= '0;
        else if (busy && rise_tick && op_q != OP_WRITE && idx >= DAT_IDX)
            rx_sh <= {rx_sh[DATA_W-2:0], mdio_in};
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// Management master top: register window, command acceptance with priority,
// status flags and the scan loop's result handling around the clock generator
// and frame engine. Assumes DATA_W >= 13 so the address register fits.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PHY_W   = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam int REG_LSB = 8;
    localparam int LINK_BIT = 2;

    logic [DIV_W-1:0]  div_q, div_run;
    logic              nopre_q;
    logic [2:0]        cmd_q;
    logic [PHY_W-1:0]  phy_q, regad_q;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic              link_fail_q, rx_inval_q;
    logic              busy, rise_tick, fall_tick, frame_done, start, cmd_wr;
    mgmt_op_e          op_sel, op_run;
    logic [DATA_W-1:0] rx_word;

    assign cmd_wr = reg_wr && (reg_addr == REG_CMD);
    assign start  = cmd_wr && !busy && (reg_wdata[2:0] != 3'b000);
    assign op_sel = reg_wdata[0] ? OP_SCAN : (reg_wdata[1] ? OP_READ : OP_WRITE);

    // Software-written registers; divider bit 0 is forced low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0; nopre_q <= 1'b0; cmd_q <= '0;
            phy_q <= '0; regad_q <= '0; tx_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                REG_MODE: begin
                    div_q   <= {reg_wdata[DIV_W-1:1], 1'b0};
                    nopre_q <= reg_wdata[DIV_W];
                end
                REG_CMD:    cmd_q <= reg_wdata[2:0];
                REG_ADDR: begin
                    phy_q   <= reg_wdata[PHY_W-1:0];
                    regad_q <= reg_wdata[REG_LSB+PHY_W-1:REG_LSB];
                end
                REG_TXDATA: tx_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Divider snapshot for the running frame, clamped to the minimum of 2.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_run <= DIV_W'(2);
        else if (start) div_run <= (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;
    end

    // Result and status flags: data-not-ready, received word, link fail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0; link_fail_q <= 1'b0; rx_inval_q <= 1'b0;
        end else if (start) begin
            if (op_sel != OP_WRITE) rx_inval_q <= 1'b1;
        end else if (frame_done && op_run != OP_WRITE) begin
            rx_q       <= rx_word;
            rx_inval_q <= 1'b0;
            if (op_run == OP_SCAN) link_fail_q <= ~rx_word[LINK_BIT];
        end
    end

    // Register read window.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_MODE: begin
                reg_rdata[DIV_W-1:0] = div_q;
                reg_rdata[DIV_W]     = nopre_q;
            end
            REG_CMD:    reg_rdata[2:0] = cmd_q;
            REG_ADDR: begin
                reg_rdata[PHY_W-1:0]                 = phy_q;
                reg_rdata[REG_LSB+PHY_W-1:REG_LSB]   = regad_q;
            end
            REG_TXDATA: reg_rdata = tx_q;
            REG_RXDATA: reg_rdata = rx_q;
            REG_STATUS: reg_rdata[2:0] = {rx_inval_q, busy, link_fail_q};
            default: ;
        endcase
    end

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_run),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_engine #(.PHY_W(PHY_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_sel),
        .nopre_in(nopre_q), .phy_in(phy_q), .reg_in(regad_q), .wdata_in(tx_q),
        .scan_hold(cmd_q[0]), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .mdio_in(mdio_in), .busy(busy), .op_out(op_run), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .frame_done(frame_done), .rx_word(rx_word)
    );

    // R12: an idle master keeps the clock and the pad enable low.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R7: serial line and enable hold still while the management clock is high.
    assert_stable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R8: busy only rises right after a command write.
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == REG_CMD));

    // R8: busy ends together with a falling management clock.
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc));

    // R9: the data-not-ready flag clears only when a frame has completed.
    assert_rx_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_inval_q) |-> $past(frame_done));
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    import mdio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    always #4 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int pass_n = 0;
    int total_n = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total_n++;
        if (ok) pass_n++;
        else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    endtask

    // PHY model state
    bit          nopre_b = 0;
    logic [15:0] resp_a = '0, resp_b = '0;
    int          rise_cnt = 0;
    logic [63:0] cap = '0;
    int          ncap = 0;
    longint      cyc = 0, stamp0 = 0, stamp1 = 0;
    int          r7_bad = 0;
    logic        prev_out = 0, prev_mdc = 0;

    function automatic logic resp_bit(input int k);
        int flen = nopre_b ? 32 : 64;
        int ds = (nopre_b ? 0 : 32) + 16;
        int pos = k % flen;
        logic [15:0] w = (k / flen == 0) ? resp_a : resp_b;
        if (pos >= ds && pos < ds + 16) return w[15 - (pos - ds)];
        return 1'b1;
    endfunction

    always @(posedge clk) cyc++;

    always @(posedge mdc) begin
        if (mdio_oe) begin
            cap = {cap[62:0], mdio_out};
            ncap++;
        end
        if (rise_cnt == 0) stamp0 = cyc;
        if (rise_cnt == 1) stamp1 = cyc;
        rise_cnt++;
    end

    always @(negedge mdc) mdio_in = resp_bit(rise_cnt);

    // R7 monitor: no change of the line between two high samples of mdc
    always @(negedge clk) begin
        if (rst_n && mdc && prev_mdc && (mdio_out !== prev_out)) r7_bad++;
        prev_mdc = mdc;
        prev_out = mdio_out;
    end

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic start_op(input logic [2:0] cmd, input bit np, input logic [7:0] dv,
                            input logic [4:0] ph, input logic [4:0] rg, input logic [15:0] dt);
        wr_reg(REG_MODE, {7'b0, np, dv});
        wr_reg(REG_ADDR, {3'b0, rg, 3'b0, ph});
        wr_reg(REG_TXDATA, dt);
        nopre_b = np; resp_a = dt; resp_b = dt;
        cap = '0; ncap = 0; rise_cnt = 0; mdio_in = 1'b1;
        wr_reg(REG_CMD, {13'b0, cmd});
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] st;
        n = 0;
        rd_reg(REG_STATUS, st);
        while (st[1] && !done_flag) begin
            n++;
            @(negedge clk);
            rd_reg(REG_STATUS, st);
        end
    endtask

    // Expected captured stream (driven bits only) from R4/R5/R6/R11
    task automatic exp_frame(input logic [2:0] cmd, input bit np, input logic [4:0] ph,
                             input logic [4:0] rg, input logic [15:0] dt,
                             output logic [63:0] e, output int n);
        bit rd = cmd[0] | cmd[1];
        logic [13:0] hdr = {2'b01, rd ? 2'b10 : 2'b01, ph, rg};
        if (rd) begin e = {50'b0, hdr}; n = 14; end
        else begin e = {32'b0, hdr, 2'b10, dt}; n = 32; end
        if (!np) begin
            e = e | (64'hFFFF_FFFF << n);
            n += 32;
        end
    endtask

    function automatic int eff_div(input logic [7:0] d);
        logic [7:0] e = {d[7:1], 1'b0};
        return (e < 2) ? 2 : int'(e);
    endfunction

    // {cmd[2:0], nopre, div[7:0], phy[4:0], reg[4:0], data/resp[15:0]}
    localparam int NV = 7;
    localparam logic [37:0] VECS [NV] = '{
        {3'b100, 1'b0, 8'd4, 5'h01, 5'h00, 16'hA5C3},
        {3'b010, 1'b0, 8'd6, 5'h1F, 5'h01, 16'h1234},
        {3'b100, 1'b1, 8'd2, 5'h0A, 5'h15, 16'h8001},
        {3'b010, 1'b1, 8'd8, 5'h05, 5'h1F, 16'hBEEF},
        {3'b100, 1'b1, 8'd7, 5'h12, 5'h04, 16'h0F0F},
        {3'b010, 1'b0, 8'd1, 5'h00, 5'h02, 16'h0001},
        {3'b010, 1'b1, 8'd0, 5'h11, 5'h0E, 16'h8000}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            chk(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", pass_n, total_n);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [63:0] e;
        int n, nb, dv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_reg(REG_STATUS, v); chk(v == 16'h0, "R1 status", v, 0);
        rd_reg(REG_MODE, v);   chk(v == 16'h0, "R1 mode", v, 0);
        rd_reg(REG_RXDATA, v); chk(v == 16'h0, "R1 rxdata", v, 0);
        chk({mdc, mdio_out, mdio_oe} == 3'b000, "R1 pins", {mdc, mdio_out, mdio_oe}, 0);

        // R2: register readback and field layout
        wr_reg(REG_MODE, 16'hFFFF);
        rd_reg(REG_MODE, v); chk(v == 16'h01FE, "R2 mode bit0 forced", v, 16'h01FE);
        wr_reg(REG_ADDR, 16'hFFFF);
        rd_reg(REG_ADDR, v); chk(v == 16'h1F1F, "R2 address fields", v, 16'h1F1F);

        // Vector table: R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  c  = VECS[i][37:35];
            bit          np = VECS[i][34];
            logic [7:0]  d  = VECS[i][33:26];
            logic [4:0]  ph = VECS[i][25:21];
            logic [4:0]  rg = VECS[i][20:16];
            logic [15:0] dt = VECS[i][15:0];
            dv = eff_div(d);
            start_op(c, np, d, ph, rg, dt);
            wait_idle(nb);
            exp_frame(c, np, ph, rg, dt, e, n);
            chk(cap == e, c[2] ? "R4 write bits" : "R5 read header bits", cap, e);
            chk(ncap == n, np ? "R6 driven bit count" : "R4/R5 driven bit count", ncap, n);
            chk(nb == (np ? 32 : 64) * dv, "R3 frame length", nb, (np ? 32 : 64) * dv);
            chk(stamp1 - stamp0 == dv, "R3 mdc period", stamp1 - stamp0, dv);
            if (!c[2]) begin
                rd_reg(REG_RXDATA, v); chk(v == dt, "R5 read data", v, dt);
                rd_reg(REG_STATUS, v); chk(v[2] == 1'b0, "R9 data ready", v, 0);
            end
            wr_reg(REG_CMD, 16'h0);
        end

        // R8: command while busy is ignored; R12 idle quiet afterwards
        start_op(3'b100, 1'b0, 8'd4, 5'h03, 5'h07, 16'h6E21);
        rd_reg(REG_STATUS, v); chk(v[1] == 1'b1, "R8 busy after accept", v, 2);
        wr_reg(REG_CMD, 16'h0002);
        wait_idle(nb);
        exp_frame(3'b100, 1'b0, 5'h03, 5'h07, 16'h6E21, e, n);
        chk(cap == e, "R8 frame unaffected", cap, e);
        chk(nb == 64 * 4 - 2, "R8 busy not extended", nb, 64 * 4 - 2);
        repeat (20) @(negedge clk);
        rd_reg(REG_STATUS, v); chk(v[1] == 1'b0, "R8 no restart", v, 0);
        chk({mdc, mdio_oe} == 2'b00, "R12 idle pins", {mdc, mdio_oe}, 0);
        rd_reg(REG_CMD, v); chk(v == 16'h0002, "R2 command readback", v, 2);
        wr_reg(REG_CMD, 16'h0);

        // R9: data-not-ready flag during a read
        start_op(3'b010, 1'b1, 8'd2, 5'h02, 5'h03, 16'h5A5A);
        rd_reg(REG_STATUS, v); chk(v[2:1] == 2'b11, "R9 not ready while reading", v, 6);
        wait_idle(nb);
        rd_reg(REG_STATUS, v); chk(v[2] == 1'b0, "R9 ready after read", v, 0);
        wr_reg(REG_CMD, 16'h0);

        // R11: read wins over write
        start_op(3'b110, 1'b1, 8'd2, 5'h03, 5'h04, 16'h3C3C);
        wait_idle(nb);
        exp_frame(3'b010, 1'b1, 5'h03, 5'h04, 16'h3C3C, e, n);
        chk(cap == e, "R11 read over write", cap, e);
        rd_reg(REG_RXDATA, v); chk(v == 16'h3C3C, "R11 read data", v, 16'h3C3C);
        wr_reg(REG_CMD, 16'h0);

        // R10 and R11: scan (with write bit too) repeats, updates data and link fail
        start_op(3'b101, 1'b1, 8'd2, 5'h01, 5'h01, 16'h0000);
        resp_b = 16'h0004;
        rd_reg(REG_STATUS, v);
        while (v[2] && !done_flag) begin @(negedge clk); rd_reg(REG_STATUS, v); end
        chk(v[1:0] == 2'b11, "R10 link fail set, still busy", v, 3);
        rd_reg(REG_RXDATA, v); chk(v == 16'h0000, "R10 first scan word", v, 0);
        while (rise_cnt < 65 && !done_flag) @(negedge clk);
        @(negedge clk);
        rd_reg(REG_RXDATA, v); chk(v == 16'h0004, "R10 second scan word", v, 4);
        rd_reg(REG_STATUS, v); chk(v[1:0] == 2'b10, "R10 link ok, still busy", v, 2);
        wr_reg(REG_CMD, 16'h0);
        wait_idle(nb);
        chk(rise_cnt % 32 == 0, "R10 scan ends on frame boundary", rise_cnt % 32, 0);
        rd_reg(REG_STATUS, v); chk(v[1] == 1'b0, "R10 scan stopped", v, 0);

        chk(r7_bad == 0, "R7 line stable while mdc high", r7_bad, 0);

        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", pass_n, total_n);
            $finish;
        end
    end
endmodule